// File: doc/BRIEF.md
# Weight Duplication Shuffler

This block takes one 32-bit word of packed weights and fans it out to four processing elements. The weights in the word are 2, 4 or 8 bits wide, so the word holds 16, 8 or 4 of them. The weight width is set by a configuration input that stays fixed for a whole run. A duplication factor, which may change from one layer to the next, sets how many elements receive the same slice of the word: one, two or all four. With a low factor every element gets its own weights, which favours activation reuse. With a high factor the elements share weights and each works on different activations.

Each element has a 32-bit output lane. The block also reports how many valid weights each lane holds. Slicing and the weight count are combinational. The results are held in an output register that takes a new value only on a cycle where the load strobe is high.

Top module: `weight_dup_shuffler`

## Requirements
- R1: While reset (rstN low) is asserted, every bit of peWeights and validCnt is zero, and both stay zero until the first load.
- R2: With dupFactor = 1, lane k (peWeights[32k+31:32k], k = 0..3) receives wordIn[8k+7:8k] in its bits [7:0], and its bits [31:8] are zero.
- R3: With dupFactor = 2, lanes 0 and 1 each receive wordIn[15:0], and lanes 2 and 3 each receive wordIn[31:16], in their bits [15:0]. Their bits [31:16] are zero.
- R4: With dupFactor = 4, all four lanes receive the whole of wordIn.
- R5: dupFactor values 0, 3, 5, 6 and 7 give the same lanes as dupFactor = 1.
- R6: validCnt equals 8·d/w. Here d is the effective duplication factor (1, 2 or 4). w is the weight width: wCfg = 0 gives 2 bits, 1 gives 4 bits, 2 gives 8 bits, and 3 is taken as 8 bits.
- R7: peWeights and validCnt change only at a rising clock edge where loadEn is high. The new values are visible in the cycle after that edge. With loadEn low, the outputs hold whatever wordIn, dupFactor or wCfg do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load strobe for the output register |
| dupFactor | input | 3 | Duplication factor: 1, 2 or 4. Any other value acts as 1 |
| wCfg | input | 2 | Weight width code: 0 = 2 bits, 1 = 4 bits, 2 or 3 = 8 bits |
| wordIn | input | 32 | Word of packed weights |
| peWeights | output | 128 | Four 32-bit element lanes, lane k at bits [32k+31:32k] |
| validCnt | output | 5 | Number of valid weights in each lane |

## Verification
A wrong decode of the duplication mode shows up as a wrong lane content in the cycle right after the load: a lane gets the wrong byte or half-word, the upper bits are not zeroed, or a shared lane differs from its partner. A wrong width decode shows up in validCnt in that same cycle. A faulty load enable shows up one cycle after any idle cycle where the inputs changed, because the outputs then move away from the values last loaded. The reference model is compared on every cycle, so each of these faults is reported within one clock of its cause.

// File: rtl/wdup_pkg.sv
package wdup_pkg;

  typedef enum logic [1:0] {
    DUP_ONE  = 2'd0,
    DUP_TWO  = 2'd1,
    DUP_FOUR = 2'd2
  } dupMode_e;

  // strobes and decoded settings passed from control to datapath
  typedef struct packed {
    logic     loadStb;
    dupMode_e dupMode;
    logic [1:0] wLog2;   // log2 of the weight width in bits
  } shufCtrl_t;

endpackage

// File: rtl/wdup_ctrl.sv
module wdup_ctrl
  import wdup_pkg::*;
(
  input  logic       loadEn,
  input  logic [2:0] dupFactor,
  input  logic [1:0] wCfg,
  output shufCtrl_t  ctrlOut
);

  dupMode_e modeDec;
  logic [1:0] wLog2Dec;

  always_comb begin
    unique case (dupFactor)
      3'd2:    modeDec = DUP_TWO;
      3'd4:    modeDec = DUP_FOUR;
      default: modeDec = DUP_ONE;   // 1 and every illegal code
    endcase
  end

  always_comb begin
    unique case (wCfg)
      2'd0:    wLog2Dec = 2'd1;
      2'd1:    wLog2Dec = 2'd2;
      default: wLog2Dec = 2'd3;     // 8-bit, also for the spare code
    endcase
  end

  always_comb begin
    ctrlOut.loadStb = loadEn;
    ctrlOut.dupMode = modeDec;
    ctrlOut.wLog2   = wLog2Dec;
  end

  always_comb begin
    p_mode_legal_r5 : assert (ctrlOut.dupMode != dupMode_e'(2'd3));
  end

endmodule

// File: rtl/wdup_datapath.sv
module wdup_datapath
  import wdup_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_PE = 4,
  parameter int CNT_W  = $clog2(WORD_W / 2 + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  shufCtrl_t                ctrlIn,
  input  logic [WORD_W-1:0]        wordIn,
  output logic [NUM_PE*WORD_W-1:0] peBus,
  output logic [CNT_W-1:0]         validCnt
);

  localparam int LANE_W = WORD_W / NUM_PE;
  localparam int PAIR_W = 2 * LANE_W;

  logic [NUM_PE-1:0][WORD_W-1:0] nextBus;
  logic [NUM_PE-1:0][WORD_W-1:0] busQ;
  logic [CNT_W-1:0]              cntNext;
  logic [CNT_W-1:0]              cntQ;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_lane
    logic [WORD_W-1:0] laneNext;

    always_comb begin
      laneNext = '0;
      unique case (ctrlIn.dupMode)
        DUP_TWO:  laneNext[PAIR_W-1:0] = wordIn[(k/2)*PAIR_W +: PAIR_W];
        DUP_FOUR: laneNext             = wordIn;
        default:  laneNext[LANE_W-1:0] = wordIn[k*LANE_W +: LANE_W];
      endcase
    end

    assign nextBus[k] = laneNext;
    assign peBus[k*WORD_W +: WORD_W] = busQ[k];

    p_lane_dup1_r2 : assert property (@(posedge clk) disable iff (!rstN)
      (ctrlIn.loadStb && ctrlIn.dupMode == DUP_ONE)
        |=> busQ[k] == WORD_W'($past(wordIn[k*LANE_W +: LANE_W])));

    p_lane_bcast_r4 : assert property (@(posedge clk) disable iff (!rstN)
      (ctrlIn.loadStb && ctrlIn.dupMode == DUP_FOUR)
        |=> busQ[k] == $past(wordIn));
  end

  // valid weights per lane: lane bits in use divided by the weight width
  always_comb begin
    int unsigned usedBits;
    unique case (ctrlIn.dupMode)
      DUP_TWO:  usedBits = PAIR_W;
      DUP_FOUR: usedBits = WORD_W;
      default:  usedBits = LANE_W;
    endcase
    cntNext = CNT_W'(usedBits >> ctrlIn.wLog2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busQ <= '0;
      cntQ <= '0;
    end else if (ctrlIn.loadStb) begin
      busQ <= nextBus;
      cntQ <= cntNext;
    end
  end

  assign validCnt = cntQ;

  p_hold_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.loadStb |=> ($stable(busQ) && $stable(cntQ)));

  p_pair_share_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.loadStb && ctrlIn.dupMode == DUP_TWO)
      |=> (busQ[0] == busQ[1] && busQ[0][WORD_W-1:PAIR_W] == '0));

  p_cnt_range_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.loadStb |=> (cntQ != '0 && cntQ <= CNT_W'(WORD_W / 2)));

endmodule

// File: rtl/weight_dup_shuffler.sv
module weight_dup_shuffler
  import wdup_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_PE = 4,
  parameter int CNT_W  = $clog2(WORD_W / 2 + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [2:0]               dupFactor,
  input  logic [1:0]               wCfg,
  input  logic [WORD_W-1:0]        wordIn,
  output logic [NUM_PE*WORD_W-1:0] peWeights,
  output logic [CNT_W-1:0]         validCnt
);

  localparam int LANE_W = WORD_W / NUM_PE;

  shufCtrl_t ctrlBus;

  wdup_ctrl u_ctrl (
    .loadEn    (loadEn),
    .dupFactor (dupFactor),
    .wCfg      (wCfg),
    .ctrlOut   (ctrlBus)
  );

  wdup_datapath #(
    .WORD_W (WORD_W),
    .NUM_PE (NUM_PE),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .wordIn   (wordIn),
    .peBus    (peWeights),
    .validCnt (validCnt)
  );

  p_illegal_as_one_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !(dupFactor == 3'd1 || dupFactor == 3'd2 || dupFactor == 3'd4))
      |=> (peWeights[WORD_W-1:LANE_W] == '0
           && peWeights[LANE_W-1:0] == $past(wordIn[LANE_W-1:0])));

endmodule

// File: tb/weight_dup_shuffler_bench.sv
module weight_dup_shuffler_bench;

  localparam time PERIOD = 20ns;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadEn = 1'b0;
  logic [2:0]   dupFactor = 3'd1;
  logic [1:0]   wCfg = 2'd0;
  logic [31:0]  wordIn = '0;
  logic [127:0] peWeights;
  logic [4:0]   validCnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  weight_dup_shuffler u_weight_dup_shuffler (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .dupFactor (dupFactor),
    .wCfg      (wCfg),
    .wordIn    (wordIn),
    .peWeights (peWeights),
    .validCnt  (validCnt)
  );

  function automatic int effDup(input logic [2:0] f);
    if (f == 3'd2) return 2;
    if (f == 3'd4) return 4;
    return 1;
  endfunction

  function automatic logic [127:0] refBus(input logic [31:0] w, input logic [2:0] f);
    int d;
    int laneBits;
    logic [63:0] mask;
    logic [127:0] r;
    d = effDup(f);
    laneBits = 8 * d;
    mask = (64'd1 << laneBits) - 64'd1;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [63:0] v;
      v = ({32'd0, w} >> ((k / d) * laneBits)) & mask;
      r[k*32 +: 32] = v[31:0];
    end
    return r;
  endfunction

  function automatic logic [4:0] refCnt(input logic [2:0] f, input logic [1:0] wc);
    int wb;
    wb = (wc == 2'd0) ? 2 : (wc == 2'd1) ? 4 : 8;
    return 5'((8 * effDup(f)) / wb);
  endfunction

  function automatic string tagFor(input logic [2:0] f);
    if (f == 3'd1) return "R2";
    if (f == 3'd2) return "R3";
    if (f == 3'd4) return "R4";
    return "R5";
  endfunction

  // reference model, advanced on every clock edge
  logic [127:0] expBus = '0;
  logic [4:0]   expCnt = '0;
  string        busTag = "R1";
  string        cntTag = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expBus <= '0;
      expCnt <= '0;
      busTag <= "R1";
      cntTag <= "R1";
    end else if (loadEn) begin
      expBus <= refBus(wordIn, dupFactor);
      expCnt <= refCnt(dupFactor, wCfg);
      busTag <= tagFor(dupFactor);
      cntTag <= "R6";
    end else if (busTag != "R1") begin
      busTag <= "R7";
      cntTag <= "R7";
    end
  end

  task automatic compareNow();
    checks++;
    if (peWeights !== expBus) begin
      fails++;
      $display("FAIL %s peWeights actual=%h expected=%h", busTag, peWeights, expBus);
    end
    checks++;
    if (validCnt !== expCnt) begin
      fails++;
      $display("FAIL %s validCnt actual=%0d expected=%0d", cntTag, validCnt, expCnt);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compareNow();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, all requirements, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    // R1: reset state, then idle cycles before any load
    step();
    step();
    rstN = 1'b1;
    wordIn = 32'hDEAD_BEEF;
    dupFactor = 3'd4;
    step();
    step();

    for (int f = 0; f < 8; f++) begin
      for (int wc = 0; wc < 4; wc++) begin
        for (int rep = 0; rep < 3; rep++) begin
          if (rep == 0)      w = 32'hFFFF_FFFF;
          else if (rep == 1) w = 32'h0123_4567 ^ (32'(f * 4 + wc) * 32'h1F3D_5B79);
          else               w = 32'h89AB_CDEF + 32'(f) * 32'h0101_0101 + 32'(wc);
          // load (R2..R6 depending on factor)
          loadEn = 1'b1;
          dupFactor = 3'(f);
          wCfg = 2'(wc);
          wordIn = w;
          step();
          // idle with changed inputs: R7 hold
          loadEn = 1'b0;
          dupFactor = 3'(7 - f);
          wCfg = 2'(3 - wc);
          wordIn = ~w;
          step();
        end
      end
    end

    // back-to-back loads with alternating factors (R2, R3, R4, R7)
    for (int i = 0; i < 12; i++) begin
      loadEn = 1'b1;
      dupFactor = (i % 3 == 0) ? 3'd1 : (i % 3 == 1) ? 3'd2 : 3'd4;
      wCfg = 2'(i % 3);
      wordIn = 32'hA5C3_0F96 + 32'(i) * 32'h1357_9BDF;
      step();
    end
    loadEn = 1'b0;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule